// File: doc/BRIEF.md
# Field Noise Level Classifier

This block watches a stream of 8-bit luminance samples and, once per video field, measures how noisy the picture is. It takes its measurement on the fourth line of each field, an early blanking line that stays clear of lines carrying inserted data. Over a fixed window of 256 consecutive samples on that line it adds up the absolute steps between neighbouring samples. The sum divided by the window length gives an 8-bit noise figure.

Two programmable limits sort the noise figure into a low, middle or high class. A downstream temporal noise reducer reads the 2-bit class code and picks a filter parameter set from it, so the class selects how much noise reduction is applied. The class changes only on a field-start strobe, which keeps the filter parameters fixed for a whole field. A tape-source mode bit turns the adaptation off and holds the class at the middle value.

The luma input is a valid/ready stream. The block never applies back-pressure: `s_ready` stays high, and every cycle with `s_valid` high delivers exactly one sample. The sync strobes and the control inputs are plain level or pulse pins.

Top module: `fnc_classifier`

## Requirements
- R1: After reset `noise_class` is 1 (middle class). It stays 1 until a field start follows a completed measurement.
- R2: `s_ready` is always 1. A sample is taken only in cycles with `s_valid` high, and cycles with `s_valid` low leave the sample index unchanged.
- R3: `field_start` clears the line count and each `line_start` adds one to it. Only samples on the line where the count is 4 feed the measurement. Samples on every other line have no effect.
- R4: Accepted samples on a line are indexed from 0 starting at its `line_start`. The noise figure is floor(sum over k=16..271 of |x[k]-x[k-1]| / 256).
- R5: At a field start the figure is classified. If it is greater than `thr_upper` the class is 2. Otherwise, if it is less than `thr_lower`, the class is 0. Any other figure gives class 1, so a figure equal to a limit gives class 1. The upper comparison wins when both would hold. Code 3 never appears.
- R6: `noise_class` changes only in the cycle after a `field_start` pulse and is stable at all other times.
- R7: If the measurement line of a field ends before index 271, no measurement completes. The next field start then leaves `noise_class` unchanged.
- R8: A field start with `vcr_mode` high sets `noise_class` to 1 whatever was measured. `vcr_mode` is sampled only at field starts.
- R9: `thr_upper` and `thr_lower` are sampled only at field starts. Changing them within a field has no effect on `noise_class`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Luma sample present |
| s_ready | output | 1 | Always high; the block takes every sample |
| s_luma | input | 8 | Luma sample value |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| field_start | input | 1 | One-cycle pulse at the start of each field, before its first line |
| vcr_mode | input | 1 | Tape-source mode; forces the middle class |
| thr_upper | input | 8 | Upper boundary of the middle class |
| thr_lower | input | 8 | Lower boundary of the middle class |
| noise_class | output | 2 | 0 low, 1 middle, 2 high noise |

## Verification
The assertions assume that `field_start` and `line_start` are single-cycle pulses that never coincide with an accepted sample. They also assume that `field_start` comes before the first `line_start` of its field. The bench raises each strobe in a cycle of its own with `s_valid` low and sends samples only between strobes. Random idle gaps with junk data on the bus test that only valid cycles count. The bench computes expected classes from the accepted samples it recorded.

// File: rtl/fnc_pkg.sv
package fnc_pkg;
  typedef enum logic [1:0] {
    NC_LOW  = 2'd0,
    NC_MID  = 2'd1,
    NC_HIGH = 2'd2
  } ncls_t;

  function automatic ncls_t fnc_classify(input logic [7:0] fig,
                                         input logic [7:0] hi,
                                         input logic [7:0] lo);
    if (fig > hi)      return NC_HIGH;
    else if (fig < lo) return NC_LOW;
    else               return NC_MID;
  endfunction
endpackage

// File: rtl/fnc_line_tracker.sv
module fnc_line_tracker #(
  parameter int LINE_W    = 10,
  parameter int IDX_W     = 12,
  parameter int MEAS_LINE = 4,
  parameter int WIN_OFS   = 16,
  parameter int WIN_END   = 271
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic line_start,
  input  logic field_start,
  output logic win_en,
  output logic win_first,
  output logic win_last
);
  localparam logic [LINE_W-1:0] MEAS_L = LINE_W'(MEAS_LINE);
  localparam logic [IDX_W-1:0]  OFS_I  = IDX_W'(WIN_OFS);
  localparam logic [IDX_W-1:0]  END_I  = IDX_W'(WIN_END);

  logic [LINE_W-1:0] line_cnt;
  logic [IDX_W-1:0]  samp_idx;
  logic              on_meas_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
    end else if (field_start) begin
      line_cnt <= '0;
    end else if (line_start && line_cnt != '1) begin
      line_cnt <= line_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_idx <= '0;
    end else if (line_start || field_start) begin
      samp_idx <= '0;
    end else if (accept && samp_idx != '1) begin
      samp_idx <= samp_idx + 1'b1;
    end
  end

  always_comb begin
    on_meas_line = (line_cnt == MEAS_L);
    win_en       = accept && on_meas_line && (samp_idx >= OFS_I) && (samp_idx <= END_I);
    win_first    = (samp_idx == OFS_I);
    win_last     = (samp_idx == END_I);
  end
endmodule

// File: rtl/fnc_diff_accum.sv
module fnc_diff_accum #(
  parameter int DATA_W   = 8,
  parameter int WIN_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] luma,
  input  logic              win_en,
  input  logic              win_first,
  input  logic              win_last,
  output logic              meas_valid,
  output logic [DATA_W-1:0] meas_fig
);
  localparam int ACC_W = DATA_W + WIN_LOG2;

  logic [DATA_W-1:0] prev_luma;
  logic [DATA_W-1:0] step;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  acc_next;

  always_comb begin
    step     = (luma >= prev_luma) ? (luma - prev_luma) : (prev_luma - luma);
    acc_next = win_first ? ACC_W'(step) : (acc + ACC_W'(step));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_luma  <= '0;
      acc        <= '0;
      meas_valid <= 1'b0;
      meas_fig   <= '0;
    end else begin
      meas_valid <= 1'b0;
      if (accept) prev_luma <= luma;
      if (win_en) begin
        acc <= acc_next;
        if (win_last) begin
          meas_valid <= 1'b1;
          meas_fig   <= acc_next[ACC_W-1:WIN_LOG2];
        end
      end
    end
  end
endmodule

// File: rtl/fnc_class_decide.sv
module fnc_class_decide
  import fnc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              vcr_mode,
  input  logic [DATA_W-1:0] thr_upper,
  input  logic [DATA_W-1:0] thr_lower,
  input  logic              meas_valid,
  input  logic [DATA_W-1:0] meas_fig,
  output ncls_t             cls
);
  logic              have_fig;
  logic [DATA_W-1:0] held_fig;
  logic              nxt_have;
  logic [DATA_W-1:0] nxt_fig;

  always_comb begin
    nxt_have = have_fig | meas_valid;
    nxt_fig  = meas_valid ? meas_fig : held_fig;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_fig <= 1'b0;
      held_fig <= '0;
      cls      <= NC_MID;
    end else if (field_start) begin
      have_fig <= 1'b0;
      if (vcr_mode)      cls <= NC_MID;
      else if (nxt_have) cls <= fnc_classify(8'(nxt_fig), 8'(thr_upper), 8'(thr_lower));
    end else if (meas_valid) begin
      have_fig <= 1'b1;
      held_fig <= meas_fig;
    end
  end
endmodule

// File: rtl/fnc_classifier.sv
module fnc_classifier
  import fnc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int WIN_LOG2  = 8,
  parameter int WIN_OFS   = 16,
  parameter int MEAS_LINE = 4,
  parameter int LINE_W    = 10,
  parameter int IDX_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_luma,
  input  logic              line_start,
  input  logic              field_start,
  input  logic              vcr_mode,
  input  logic [DATA_W-1:0] thr_upper,
  input  logic [DATA_W-1:0] thr_lower,
  output logic [1:0]        noise_class
);
  localparam int WIN_LEN = 1 << WIN_LOG2;
  localparam int WIN_END = WIN_OFS + WIN_LEN - 1;

  logic  accept;
  logic  win_en, win_first, win_last;
  logic  meas_valid;
  logic [DATA_W-1:0] meas_fig;
  ncls_t cls;

  assign s_ready     = 1'b1;
  assign accept      = s_valid;
  assign noise_class = cls;

  fnc_line_tracker #(
    .LINE_W(LINE_W), .IDX_W(IDX_W), .MEAS_LINE(MEAS_LINE),
    .WIN_OFS(WIN_OFS), .WIN_END(WIN_END)
  ) trk_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .line_start(line_start),
    .field_start(field_start), .win_en(win_en), .win_first(win_first),
    .win_last(win_last)
  );

  fnc_diff_accum #(.DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2)) acc_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .luma(s_luma),
    .win_en(win_en), .win_first(win_first), .win_last(win_last),
    .meas_valid(meas_valid), .meas_fig(meas_fig)
  );

  fnc_class_decide #(.DATA_W(DATA_W)) dec_i (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .vcr_mode(vcr_mode),
    .thr_upper(thr_upper), .thr_lower(thr_lower), .meas_valid(meas_valid),
    .meas_fig(meas_fig), .cls(cls)
  );
endmodule

// File: rtl/fnc_checker.sv
module fnc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       s_ready,
  input logic       field_start,
  input logic       vcr_mode,
  input logic [1:0] noise_class
);
  assert_ready_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready == 1'b1);

  assert_legal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    noise_class != 2'b11);

  assert_hold_in_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(noise_class));

  assert_vcr_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && vcr_mode) |=> noise_class == 2'd1);

  assert_reset_mid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> noise_class == 2'd1);
endmodule

bind fnc_classifier fnc_checker chk_i (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .field_start(field_start),
  .vcr_mode(vcr_mode), .noise_class(noise_class)
);

// File: tb/fnc_classifier_tb_top.sv
module fnc_classifier_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_luma = 8'd0;
  logic       line_start = 1'b0;
  logic       field_start = 1'b0;
  logic       vcr_mode = 1'b0;
  logic [7:0] thr_upper = 8'd200;
  logic [7:0] thr_lower = 8'd10;
  logic [1:0] noise_class;

  int checks = 0;
  int errors = 0;
  int exp_cls = 1;
  int have_meas = 0;
  int meas_fig = 0;
  int rec [0:399];

  always #10 clk = ~clk;

  fnc_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_luma(s_luma), .line_start(line_start), .field_start(field_start),
    .vcr_mode(vcr_mode), .thr_upper(thr_upper), .thr_lower(thr_lower),
    .noise_class(noise_class)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_class(input int fig, input int hi, input int lo);
    if (fig > hi) return 2;
    if (fig < lo) return 0;
    return 1;
  endfunction

  function automatic int ref_fig(input int n);
    int s = 0;
    if (n < 272) return -1;
    for (int k = 16; k <= 271; k++)
      s += (rec[k] > rec[k-1]) ? rec[k] - rec[k-1] : rec[k-1] - rec[k];
    return s / 256;
  endfunction

  task automatic start_field(input int vcr, input int hi, input int lo);
    @(negedge clk);
    field_start = 1'b1; vcr_mode = 1'(vcr);
    thr_upper = 8'(hi); thr_lower = 8'(lo);
    if (vcr != 0) exp_cls = 1;
    else if (have_meas != 0) exp_cls = ref_class(meas_fig, hi, lo);
    have_meas = 0;
    @(negedge clk);
    field_start = 1'b0;
    check("R5/R7/R8 class at field start", int'(noise_class), exp_cls);
    check("R2 ready", int'(s_ready), 1);
  endtask

  // mode 0 flat, 1 alternating step of amp, 2 random within amp
  task automatic send_line(input int n, input int meas, input int mode, input int amp);
    @(negedge clk);
    s_valid = 1'b0; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      while ($urandom % 4 == 0) begin
        s_valid = 1'b0; s_luma = 8'($urandom);
        @(negedge clk);
      end
      case (mode)
        0:       s_luma = 8'd100;
        1:       s_luma = 8'(100 + ((i % 2) * amp));
        default: s_luma = 8'(100 + ($urandom % (amp + 1)));
      endcase
      s_valid = 1'b1;
      if (meas != 0 && i < 400) rec[i] = int'(s_luma);
      @(negedge clk);
    end
    s_valid = 1'b0;
  endtask

  task automatic run_field(input int vcr, input int hi, input int lo, input int mode,
                           input int amp, input int len4, input int poke);
    int f;
    start_field(vcr, hi, lo);
    send_line(20, 0, 2, 150);
    if (poke != 0) begin
      vcr_mode = ~vcr_mode; thr_upper = 8'd0; thr_lower = 8'd255;
    end
    send_line(20, 0, 2, 150);
    send_line(300, 0, 2, 150);   // R3: a noisy line that must be ignored
    check("R6/R8/R9 stable within field", int'(noise_class), exp_cls);
    send_line(len4, 1, mode, amp);
    send_line(300, 0, 1, 150);   // R3: line 5 ignored
    f = ref_fig(len4);
    if (f >= 0) begin have_meas = 1; meas_fig = f; end
  endtask

  initial begin
    int seed_d;
    seed_d = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    check("R1 reset class", int'(noise_class), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 class after reset", int'(noise_class), 1);
    run_field(0, 40, 10, 1, 50, 280, 0);  // R1: no measurement before -> stays 1
    run_field(0, 40, 10, 1, 5, 280, 0);   // previous A=50 -> R5 high
    run_field(0, 40, 10, 1, 40, 280, 0);  // A=5 -> low
    run_field(0, 40, 10, 1, 10, 280, 0);  // A=40 tie upper -> mid
    run_field(0, 40, 10, 1, 80, 200, 0);  // A=10 tie lower -> mid; R7 short next
    run_field(0, 40, 10, 1, 60, 280, 1);  // R7 short line kept; R9 poke
    run_field(1, 40, 10, 0, 0, 280, 0);   // R8 vcr -> mid despite A=60
    run_field(0, 40, 1, 0, 0, 280, 0);    // R4 flat: fig 0 < 1 -> low
    run_field(0, 40, 0, 1, 50, 272, 0);   // fig 0, lo 0 -> mid; exact window end
    run_field(0, 5, 100, 2, 150, 300, 1); // R5 upper wins over lower
    for (int n = 0; n < 22; n++) begin
      int md = int'($urandom % 3);
      int am = int'($urandom % 151);
      int hi = int'($urandom % 120);
      int lo = int'($urandom % 80);
      int vc = ($urandom % 8 == 0) ? 1 : 0;
      int ln = 250 + int'($urandom % 50);
      run_field(vc, hi, lo, md, am, ln, int'($urandom % 2));  // R4 random windows
    end
    start_field(0, 60, 20);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule